// File: doc/BRIEF.md
# Type B Card Response Frame Encoder

This block turns a short byte string into the logical bit stream that a contactless proximity card of Type B sends back to a reader. A controller pulses a start strobe together with a byte count. The block then pulls the payload one byte at a time over a valid/ready interface. For every elementary time unit (etu) it presents one logical bit on a single output line. The payload must already end in its two CRC bytes, because the block computes none. The subcarrier phase modulation that follows this stage is outside the block.

A frame has five parts in this order. First comes a run of logic-1 etus that lets the reader train its phase reference. Next is a start-of-frame mark: ten logic-0 etus, then two logic-1 etus. Each payload byte follows as a ten-etu character. The frame closes with an end-of-frame mark of the same low/high shape. An external tick input ends the current etu, and the block moves forward only on that tick. A one-byte holding register fetches the next byte while the current character is still being sent. If a byte arrives late, the line stays at logic 1 for whole extra etus until the byte is there. When the last etu has been sent, a single-cycle done pulse marks the end of the frame.

Top module: `typeb_resp_encoder`

## Requirements
- R1: After reset and between frames, the bit output is 1 and busy, done and byte_ready are 0. Ticks and offered bytes while idle change none of these.
- R2: A start strobe is taken only while idle. A start strobe during a frame leaves the frame's bit stream and byte count unchanged.
- R3: The frame opens with PRE_ETUS (default 20) etus of logic 1. Each etu ends only at a cycle where etu_tick is high, and the output does not advance without a tick.
- R4: After the preamble comes a start mark of MARK_LO_ETUS (10) etus of logic 0, then MARK_HI_ETUS (2) etus of logic 1.
- R5: Each payload byte is sent as 10 etus: a start bit of 0, then the 8 data bits least significant bit first, then a stop bit of 1. Bytes go out in the order they were accepted.
- R6: After the last character comes an end mark of 10 etus of 0 and then 2 etus of 1. done is high for exactly one cycle, in the cycle right after the tick that ends the final etu, and busy is already low in that cycle.
- R7: A start with length 0 sends only the preamble, the start mark and the end mark, and it never raises byte_ready.
- R8: A byte is taken in a cycle where byte_valid and byte_ready are both high. byte_ready is high only during a frame while some of the requested bytes are still unfetched, so exactly len_i bytes are taken per frame.
- R9: The block holds at most one byte ahead. In the cycle where a boundary tick moves the held byte into the character shifter, byte_ready is high, and a byte offered in that same cycle is taken without adding any etu.
- R10: If no byte is held when a character should begin, each tick ends one extra etu of logic 1. With a byte released after G further ticks, exactly G+1 guard etus appear before its start bit.
- R11: A start strobe given in the cycle where done is high is accepted, so a new frame follows directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Frame start strobe, taken while idle |
| len_i | input | LEN_W | Payload byte count, sampled with the start strobe |
| byte_valid_i | input | 1 | Payload byte offered |
| byte_data_i | input | 8 | Payload byte |
| byte_ready_o | output | 1 | Byte taken when valid is also high |
| etu_tick_i | input | 1 | Ends the current etu |
| bit_o | output | 1 | Logical value of the current etu |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the last etu |

## Verification
Two things can happen in the same cycle: a boundary tick moves the held byte into the character shifter, and a new byte is taken into the now-free holding register. The bench holds back one byte until exactly the cycle of the tick that consumes its predecessor. It then checks that byte_ready is high in that cycle and that the recorded etu stream matches a gap-free frame. The second pair is the done pulse and a new start strobe in the same cycle: the bench starts the next frame in the done cycle and checks that busy is high one cycle later and that the following stream is complete.

// File: rtl/typeb_enc_pkg.sv
// Shared definitions for the Type B response encoder.
// Assumes characters are a start bit, one byte and a stop bit.
package typeb_enc_pkg;

    localparam int BYTE_W    = 8;
    localparam int CHAR_ETUS = BYTE_W + 2;

    // Frame segments in transmission order
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SOF_LO,
        PH_SOF_HI,
        PH_GAP,
        PH_CHAR,
        PH_EOF_LO,
        PH_EOF_HI
    } enc_phase_e;

endpackage

// File: rtl/typeb_enc_seq.sv
// Segment sequencer: walks the frame through preamble, start mark,
// characters (with guard etus when no byte is held) and end mark.
// Assumes etu_tick_i is a one-cycle strobe and that every segment
// length parameter is at least 1.
module typeb_enc_seq
    import typeb_enc_pkg::*;
#(
    parameter int PRE_ETUS     = 20,
    parameter int MARK_LO_ETUS = 10,
    parameter int MARK_HI_ETUS = 2,
    parameter int LEN_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             etu_tick_i,
    input  logic             nxt_full_i,
    output enc_phase_e       phase_o,
    output logic             consume_o,
    output logic             done_o
);

    localparam int MAX_A   = (PRE_ETUS > MARK_LO_ETUS) ? PRE_ETUS : MARK_LO_ETUS;
    localparam int MAX_B   = (MAX_A > MARK_HI_ETUS) ? MAX_A : MARK_HI_ETUS;
    localparam int MAX_SEG = (MAX_B > CHAR_ETUS) ? MAX_B : CHAR_ETUS;
    localparam int CNT_W   = $clog2(MAX_SEG + 1);

    enc_phase_e       phase_q, phase_d;
    logic [CNT_W-1:0] etu_cnt_q;
    logic [CNT_W-1:0] seg_last;
    logic [LEN_W-1:0] chars_left_q;
    logic             done_q;
    logic             seg_end;
    logic             at_boundary;
    logic             more_chars;

    // Last etu index of the current segment
    always_comb begin : seg_len_sel
        unique case (phase_q)
            PH_PRE:               seg_last = CNT_W'(PRE_ETUS - 1);
            PH_SOF_LO, PH_EOF_LO: seg_last = CNT_W'(MARK_LO_ETUS - 1);
            PH_SOF_HI, PH_EOF_HI: seg_last = CNT_W'(MARK_HI_ETUS - 1);
            PH_CHAR:              seg_last = CNT_W'(CHAR_ETUS - 1);
            default:              seg_last = '0;
        endcase
    end

    assign seg_end     = etu_tick_i && (phase_q != PH_IDLE) && (etu_cnt_q == seg_last);
    assign at_boundary = seg_end && (phase_q inside {PH_SOF_HI, PH_CHAR, PH_GAP});
    assign more_chars  = (chars_left_q != '0);
    assign consume_o   = at_boundary && more_chars && nxt_full_i;

    // Next segment selection
    always_comb begin : next_phase
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (start_i) phase_d = PH_PRE;
            PH_PRE:    if (seg_end) phase_d = PH_SOF_LO;
            PH_SOF_LO: if (seg_end) phase_d = PH_SOF_HI;
            PH_SOF_HI, PH_CHAR, PH_GAP: begin
                if (seg_end) begin
                    if (!more_chars)     phase_d = PH_EOF_LO;
                    else if (nxt_full_i) phase_d = PH_CHAR;
                    else                 phase_d = PH_GAP;
                end
            end
            PH_EOF_LO: if (seg_end) phase_d = PH_EOF_HI;
            PH_EOF_HI: if (seg_end) phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Segment state, etu counter, remaining characters and done pulse
    always_ff @(posedge clk) begin : seq_regs
        if (!rst_n) begin
            phase_q      <= PH_IDLE;
            etu_cnt_q    <= '0;
            chars_left_q <= '0;
            done_q       <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= seg_end && (phase_q == PH_EOF_HI);
            if (phase_q == PH_IDLE || seg_end) etu_cnt_q <= '0;
            else if (etu_tick_i)               etu_cnt_q <= etu_cnt_q + CNT_W'(1);
            if (phase_q == PH_IDLE && start_i) chars_left_q <= len_i;
            else if (consume_o)                chars_left_q <= chars_left_q - LEN_W'(1);
        end
    end

    assign phase_o = phase_q;
    assign done_o  = done_q;

    // R3: without a tick the frame does not move on
    assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE && !etu_tick_i) |=> $stable(phase_q));

    // R2: a start strobe inside a frame does not reload the character count
    assert_busy_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE && start_i && !consume_o) |=> $stable(chars_left_q));

    // R6: done only follows the closing high etus
    assert_done_after_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(phase_q) == PH_EOF_HI));

    // R6: done lasts one cycle
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/typeb_enc_fetch.sv
// One-byte holding register in front of the character shifter.
// Requests bytes while a frame runs and some are still owed, and
// accepts a new byte in the cycle the held one is consumed.
module typeb_enc_fetch
    import typeb_enc_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              active_i,
    input  logic              valid_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              consume_i,
    output logic              full_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              ready_o
);

    logic [LEN_W-1:0]  owed_q;
    logic              full_q;
    logic [BYTE_W-1:0] hold_q;
    logic              take;

    assign ready_o = active_i && (owed_q != '0) && (!full_q || consume_i);
    assign take    = valid_i && ready_o;

    // Owed count, holding flag and held byte
    always_ff @(posedge clk) begin : hold_regs
        if (!rst_n) begin
            owed_q <= '0;
            full_q <= 1'b0;
            hold_q <= '0;
        end else if (start_i) begin
            owed_q <= len_i;
            full_q <= 1'b0;
        end else begin
            if (take)           owed_q <= owed_q - LEN_W'(1);
            if (take)           full_q <= 1'b1;
            else if (consume_i) full_q <= 1'b0;
            if (take)           hold_q <= data_i;
        end
    end

    assign full_o = full_q;
    assign data_o = hold_q;

    // R9: the sequencer never consumes an empty holding register
    assert_consume_has_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        consume_i |-> full_q);

    // R9: a taken byte is held in the next cycle
    assert_take_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> full_q);

    // R8: outside a frame no byte is left over
    assert_idle_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |-> !full_q);

endmodule

// File: rtl/typeb_enc_shift.sv
// Character shifter: frames a byte with start and stop bits and
// presents it least significant bit first, one bit per shift.
module typeb_enc_shift
    import typeb_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              shift_i,
    output logic              bit_o
);

    logic [CHAR_ETUS-1:0] sh_q;

    // Load a framed character or move on to its next bit
    always_ff @(posedge clk) begin : shift_reg
        if (!rst_n)       sh_q <= '1;
        else if (load_i)  sh_q <= {1'b1, data_i, 1'b0};
        else if (shift_i) sh_q <= {1'b1, sh_q[CHAR_ETUS-1:1]};
    end

    assign bit_o = sh_q[0];

    // R5: a new character opens with a low start bit
    assert_start_bit_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !bit_o);

    // R5: a new character ends with a high stop bit
    assert_stop_bit_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> sh_q[CHAR_ETUS-1]);

endmodule

// File: rtl/typeb_resp_encoder.sv
// Type B card response frame encoder top. Joins the sequencer, the
// holding register and the character shifter, and maps the current
// segment to the logical etu value. Assumes CRC bytes are in the payload.
module typeb_resp_encoder
    import typeb_enc_pkg::*;
#(
    parameter int PRE_ETUS     = 20,
    parameter int MARK_LO_ETUS = 10,
    parameter int MARK_HI_ETUS = 2,
    parameter int LEN_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             byte_valid_i,
    input  logic [7:0]       byte_data_i,
    output logic             byte_ready_o,
    input  logic             etu_tick_i,
    output logic             bit_o,
    output logic             busy_o,
    output logic             done_o
);

    enc_phase_e        phase;
    logic              consume;
    logic              nxt_full;
    logic [BYTE_W-1:0] nxt_data;
    logic              char_bit;
    logic              start_acc;
    logic              active;

    assign active    = (phase != PH_IDLE);
    assign start_acc = start_i && !active;

    typeb_enc_seq #(
        .PRE_ETUS     (PRE_ETUS),
        .MARK_LO_ETUS (MARK_LO_ETUS),
        .MARK_HI_ETUS (MARK_HI_ETUS),
        .LEN_W        (LEN_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .len_i      (len_i),
        .etu_tick_i (etu_tick_i),
        .nxt_full_i (nxt_full),
        .phase_o    (phase),
        .consume_o  (consume),
        .done_o     (done_o)
    );

    typeb_enc_fetch #(
        .LEN_W (LEN_W)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_acc),
        .len_i     (len_i),
        .active_i  (active),
        .valid_i   (byte_valid_i),
        .data_i    (byte_data_i),
        .consume_i (consume),
        .full_o    (nxt_full),
        .data_o    (nxt_data),
        .ready_o   (byte_ready_o)
    );

    typeb_enc_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (consume),
        .data_i  (nxt_data),
        .shift_i (etu_tick_i && (phase == PH_CHAR)),
        .bit_o   (char_bit)
    );

    // Logical etu value for the current segment
    always_comb begin : line_value
        unique case (phase)
            PH_SOF_LO, PH_EOF_LO: bit_o = 1'b0;
            PH_CHAR:              bit_o = char_bit;
            default:              bit_o = 1'b1;
        endcase
    end

    assign busy_o = active;

endmodule

// File: tb/tb_typeb_resp_encoder.sv
// Bench for the Type B response encoder: directed corner frames plus
// seeded random frames, compared etu by etu with a computed stream.
module tb_typeb_resp_encoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] len_i = '0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_data_i = '0;
    logic       byte_ready_o;
    logic       etu_tick_i = 1'b0;
    logic       bit_o;
    logic       busy_o;
    logic       done_o;

    int checks = 0;
    int fails = 0;
    logic       exp_bits [0:4095];
    int         exp_len;
    logic [7:0] fbytes [0:63];

    always #4 clk = ~clk;

    typeb_resp_encoder dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .len_i        (len_i),
        .byte_valid_i (byte_valid_i),
        .byte_data_i  (byte_data_i),
        .byte_ready_o (byte_ready_o),
        .etu_tick_i   (etu_tick_i),
        .bit_o        (bit_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Expected etu stream: preamble, start mark, characters with guards, end mark
    function automatic void build_exp(input int len, input int d_idx, input int g);
        int n = 0;
        for (int i = 0; i < 20; i++) begin exp_bits[n] = 1'b1; n++; end
        for (int i = 0; i < 10; i++) begin exp_bits[n] = 1'b0; n++; end
        for (int i = 0; i < 2; i++)  begin exp_bits[n] = 1'b1; n++; end
        for (int k = 0; k < len; k++) begin
            if (k == d_idx)
                for (int i = 0; i <= g; i++) begin exp_bits[n] = 1'b1; n++; end
            exp_bits[n] = 1'b0; n++;
            for (int b = 0; b < 8; b++) begin exp_bits[n] = fbytes[k][b]; n++; end
            exp_bits[n] = 1'b1; n++;
        end
        for (int i = 0; i < 10; i++) begin exp_bits[n] = 1'b0; n++; end
        for (int i = 0; i < 2; i++)  begin exp_bits[n] = 1'b1; n++; end
        exp_len = n;
    endfunction

    task automatic do_frame(input int len, input int d_idx, input int g, input int c_idx,
                            input bit poke_busy, input bit skip_start,
                            input bit chain, input int next_len, input string tag);
        int ticks = 0;
        int idx = 0;
        int gap = 1;
        int cyc = 0;
        int mism = 0;
        int bad_at = -1;
        int last_tick = -10;
        bit done_seen = 0;
        bit extra_ready = 0;
        bit coincide_ok = 0;
        bit poked = 0;
        bit tick;
        bit hold;
        for (int k = 0; k < len; k++) fbytes[k] = 8'($urandom);
        build_exp(len, d_idx, g);
        if (!skip_start) begin
            @(negedge clk);
            start_i = 1'b1;
            len_i   = 8'(len);
        end
        while (!done_seen && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            start_i = 1'b0;
            etu_tick_i = 1'b0;
            byte_valid_i = 1'b0;
            if (done_o) begin
                done_seen = 1;
                check(busy_o == 1'b0, "R6", {tag, " busy in done cycle"}, busy_o, 0);
                check(last_tick == cyc - 1, "R6", {tag, " done one cycle after last tick"},
                      cyc - last_tick, 1);
                if (chain) begin
                    start_i = 1'b1;
                    len_i   = 8'(next_len);
                end
            end else begin
                tick = (gap == 0);
                gap  = tick ? $urandom_range(1, 4) : gap - 1;
                etu_tick_i = tick;
                hold = 0;
                if (idx == d_idx && !(ticks >= 32 + 10 * d_idx + g && !tick)) hold = 1;
                if (idx == c_idx && !(tick && ticks + 1 == 32 + 10 * (c_idx - 1))) hold = 1;
                if (poke_busy && !poked && ticks == 40) begin
                    poked   = 1;
                    start_i = 1'b1;
                    len_i   = 8'(len + 3);
                end
                byte_valid_i = (idx < len) && !hold;
                byte_data_i  = byte_valid_i ? fbytes[idx] : 8'($urandom);
                #1;
                if (byte_ready_o && idx >= len) extra_ready = 1;
                if (tick) begin
                    if (ticks >= exp_len || bit_o !== exp_bits[ticks]) begin
                        mism++;
                        if (bad_at < 0) bad_at = ticks;
                    end
                    ticks++;
                    last_tick = cyc;
                end
                if (byte_valid_i && byte_ready_o) begin
                    if (idx == c_idx) coincide_ok = 1;
                    idx++;
                end
            end
        end
        etu_tick_i = 1'b0;
        byte_valid_i = 1'b0;
        check(done_seen, "R6", {tag, " done pulse seen"}, done_seen, 1);
        check(mism == 0 && ticks == exp_len, "R3 R4 R5",
              {tag, " etu stream (first bad etu / length)"}, (mism == 0) ? ticks : bad_at,
              (mism == 0) ? exp_len : -1);
        check(idx == len, "R8", {tag, " bytes taken"}, idx, len);
        check(!extra_ready, "R8", {tag, " ready with no byte owed"}, extra_ready, 0);
        if (c_idx >= 0)
            check(coincide_ok, "R9", {tag, " byte taken on consuming tick"}, coincide_ok, 1);
        if (d_idx >= 0)
            check(mism == 0, "R10", {tag, " guard etus before late byte"}, mism, 0);
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b0, "R6", {tag, " done width"}, done_o, 0);
        if (chain) begin
            check(busy_o == 1'b1, "R11", {tag, " start in done cycle accepted"}, busy_o, 1);
        end else begin
            check(busy_o == 1'b0 && bit_o == 1'b1, "R1", {tag, " idle after frame (bit)"},
                  bit_o, 1);
        end
    endtask

    // Watchdog: a hung run ends as a failure
    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int mode;
        int len;
        void'($urandom(32'd4211));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(bit_o == 1'b1, "R1", "reset bit", bit_o, 1);
        check(busy_o == 1'b0, "R1", "reset busy", busy_o, 0);
        check(done_o == 1'b0, "R1", "reset done", done_o, 0);
        check(byte_ready_o == 1'b0, "R1", "reset ready", byte_ready_o, 0);

        // R1: ticks and offered bytes while idle do nothing
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            etu_tick_i   = 1'b1;
            byte_valid_i = 1'b1;
            byte_data_i  = 8'h00;
            #1;
            if (byte_ready_o) check(0, "R1", "ready while idle", 1, 0);
        end
        @(negedge clk);
        etu_tick_i = 1'b0;
        byte_valid_i = 1'b0;
        #1;
        check(bit_o == 1'b1 && busy_o == 1'b0, "R1", "idle after stray ticks", bit_o, 1);

        do_frame(1, -1, 0, -1, 0, 0, 0, 0, "single byte");
        do_frame(0, -1, 0, -1, 0, 0, 0, 0, "R7 empty frame");
        do_frame(4, -1, 0, -1, 1, 0, 0, 0, "R2 start while busy");
        do_frame(5, 2, 3, -1, 0, 0, 0, 0, "R10 late middle byte");
        do_frame(3, 0, 0, -1, 0, 0, 0, 0, "R10 late first byte");
        do_frame(4, -1, 0, 2, 0, 0, 0, 0, "R9 coincident take");
        do_frame(3, -1, 0, 1, 0, 0, 0, 0, "R9 coincident after start mark");
        do_frame(2, -1, 0, -1, 0, 0, 1, 3, "R11 chained first");
        do_frame(3, -1, 0, -1, 0, 1, 0, 0, "R11 chained second");

        for (int f = 0; f < 12; f++) begin
            len  = $urandom_range(0, 12);
            mode = $urandom_range(0, 2);
            if (mode == 1 && len > 0)
                do_frame(len, $urandom_range(0, len - 1), $urandom_range(0, 3), -1,
                         0, 0, 0, 0, "R10 random late");
            else if (mode == 2 && len > 1)
                do_frame(len, -1, 0, $urandom_range(1, len - 1), 0, 0, 0, 0,
                         "R9 random coincident");
            else
                do_frame(len, -1, 0, -1, 0, 0, 0, 0, "R5 random frame");
        end

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule